// File: doc/BRIEF.md
# PLL Divider Search Engine

This block finds the integer pre-divider and feedback-divider pair that brings a PLL output as close as possible to a requested rate. A single pulse on `start` captures the input clock frequency and the requested rate, both in hertz. The engine then walks through every legal pre-divider value. For each one it computes the feedback divider and the resulting output frequency, and it keeps the candidate with the smallest absolute error. A candidate with zero error ends the walk at once.

All divisions go through one shared restoring divider that produces one quotient bit per cycle. A search therefore takes a few divisions for its setup, plus one or two divisions per pre-divider value. The result stays on the outputs until the next accepted start. `done` marks completion for one cycle, and `valid` tells whether any candidate was accepted.

Top module: `pll_div_search`

## Requirements
- R1: The reference used by the search is half the input clock frequency, rounded down (for example, an input of 24000001 Hz behaves as a reference of 12000000 Hz).
- R2: A requested rate above 1000000000 Hz is treated as exactly 1000000000 Hz.
- R3: Pre-divider values are tried in increasing order from ceil(ref / 40 MHz) to floor(ref / 5 MHz). When that upper bound is zero, no value is tried.
- R4: For each pre-divider p, the feedback value is floor(rate × p / ref). The candidate is rejected if that value is below 12, above 511, or equal to 15.
- R5: For an accepted candidate, the achieved frequency is floor(fb × ref / p). It becomes the best only when its absolute error is strictly below the best error so far, so on a tie the earlier (smaller) pre-divider stays.
- R6: A candidate with zero error is taken and ends the search immediately, with no later pre-divider evaluated.
- R7: When no candidate is accepted, the search reports achieved frequency 0, pre-divider 1, feedback 1 and `valid` low. `valid` is high after a search that accepted at least one candidate.
- R8: `done` is high for exactly one cycle per search. The reported results do not change after `done` until the next accepted start.
- R9: A `start` pulse that arrives while a search is running is ignored, and the running search completes with its original inputs.
- R10: After reset, `done` and `valid` are low, the pre-divider and feedback outputs read 1, and the achieved frequency reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| refHz | input | 32 | Input clock frequency in Hz |
| rateHz | input | 32 | Requested output rate in Hz |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | At least one candidate was accepted |
| bestPre | output | 9 | Best pre-divider |
| bestFb | output | 9 | Best feedback divider |
| achievedHz | output | 32 | Frequency produced by the best pair |

## Verification
Several properties are checked on every cycle by the assertions. The kept feedback value never leaves the legal set. The kept pre-divider keeps the compare frequency inside its band. The defaults hold whenever nothing has been accepted. The best error never grows during a search. The clamped rate never exceeds the ceiling. `done` never lasts two cycles. Other behaviours can only be shown by the bench's scenarios against a model computed from the requirements: which pair wins a tie, that the search stops early on an exact hit (seen as a shorter search), that the halved reference rounds down, and that a start arriving mid-search leaves the result unchanged.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [1:0] {
    OP_MIN,
    OP_MAX,
    OP_FB,
    OP_FREQ
  } divOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   init;
    logic   divGo;
    divOp_e op;
    logic   latchMin;
    logic   latchMax;
    logic   latchFb;
    logic   evalFreq;
    logic   nextPre;
    logic   finish;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic divDone;
    logic fbOk;
    logic exact;
    logic preOver;
  } dpStat_t;

endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             ready,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W);

  logic [DEN_W-1:0] remR, denR, nextRem;
  logic [NUM_W-1:0] quoR, nextQuo;
  logic [CNT_W-1:0] cntR;
  logic             running;
  logic [DEN_W:0]   remSh, remDiff;

  always_comb begin
    remSh   = {remR, quoR[NUM_W-1]};
    remDiff = remSh - {1'b0, denR};
    if (remSh >= {1'b0, denR}) begin
      nextRem = remDiff[DEN_W-1:0];
      nextQuo = {quoR[NUM_W-2:0], 1'b1};
    end else begin
      nextRem = remSh[DEN_W-1:0];
      nextQuo = {quoR[NUM_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR    <= '0;
      denR    <= '0;
      quoR    <= '0;
      cntR    <= '0;
      running <= 1'b0;
      ready   <= 1'b0;
    end else begin
      ready <= 1'b0;
      if (go) begin
        quoR    <= numer;
        remR    <= '0;
        denR    <= denom;
        cntR    <= '0;
        running <= 1'b1;
      end else if (running) begin
        remR <= nextRem;
        quoR <= nextQuo;
        cntR <= cntR + 1'b1;
        if (cntR == CNT_W'(NUM_W - 1)) begin
          running <= 1'b0;
          ready   <= 1'b1;
        end
      end
    end
  end

  assign quot = quoR;

endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int          FREQ_W     = 32,
  parameter int          PRE_W      = 9,
  parameter int          FB_W       = 9,
  parameter int unsigned CLAMP_HZ   = 1000000000,
  parameter int unsigned CMP_MIN_HZ = 5000000,
  parameter int unsigned CMP_MAX_HZ = 40000000,
  parameter int unsigned FB_MIN     = 12,
  parameter int unsigned FB_MAX     = 511,
  parameter int unsigned FB_SKIP    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [FREQ_W-1:0] refHz,
  input  logic [FREQ_W-1:0] rateHz,
  output dpStat_t           stat,
  output logic              done,
  output logic              valid,
  output logic [PRE_W-1:0]  bestPre,
  output logic [FB_W-1:0]   bestFb,
  output logic [FREQ_W-1:0] achievedHz
);
  localparam int NUM_W = 2 * FREQ_W;

  logic [FREQ_W-1:0] frefR, foutR, minDelta, delta, freqQ;
  logic [PRE_W-1:0]  preR, maxPreR;
  logic [FB_W-1:0]   fbR;
  logic              found;
  logic [NUM_W-1:0]  numer, quot;
  logic [FREQ_W-1:0] denom;
  logic              divReady;

  always_comb begin
    unique case (ctl.op)
      OP_MIN: begin
        numer = NUM_W'(frefR) + NUM_W'(CMP_MAX_HZ - 1);
        denom = FREQ_W'(CMP_MAX_HZ);
      end
      OP_MAX: begin
        numer = NUM_W'(frefR);
        denom = FREQ_W'(CMP_MIN_HZ);
      end
      OP_FB: begin
        numer = NUM_W'(foutR) * NUM_W'(preR);
        denom = frefR;
      end
      default: begin
        numer = NUM_W'(fbR) * NUM_W'(frefR);
        denom = FREQ_W'(preR);
      end
    endcase
  end

  pll_search_div #(.NUM_W(NUM_W), .DEN_W(FREQ_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .go    (ctl.divGo),
    .numer (numer),
    .denom (denom),
    .ready (divReady),
    .quot  (quot)
  );

  assign freqQ = quot[FREQ_W-1:0];
  assign delta = (foutR >= freqQ) ? (foutR - freqQ) : (freqQ - foutR);

  assign stat.divDone = divReady;
  assign stat.fbOk    = (quot >= NUM_W'(FB_MIN)) && (quot <= NUM_W'(FB_MAX))
                        && (quot != NUM_W'(FB_SKIP));
  assign stat.exact   = (delta == '0);
  assign stat.preOver = (maxPreR == '0) || (preR > maxPreR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frefR      <= '0;
      foutR      <= '0;
      preR       <= '0;
      maxPreR    <= '0;
      fbR        <= '0;
      minDelta   <= '1;
      found      <= 1'b0;
      bestPre    <= PRE_W'(1);
      bestFb     <= FB_W'(1);
      achievedHz <= '0;
      done       <= 1'b0;
      valid      <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.init) begin
        frefR      <= refHz >> 1;
        foutR      <= (rateHz > FREQ_W'(CLAMP_HZ)) ? FREQ_W'(CLAMP_HZ) : rateHz;
        minDelta   <= '1;
        found      <= 1'b0;
        bestPre    <= PRE_W'(1);
        bestFb     <= FB_W'(1);
        achievedHz <= '0;
        valid      <= 1'b0;
      end
      if (ctl.latchMin) preR    <= quot[PRE_W-1:0];
      if (ctl.latchMax) maxPreR <= quot[PRE_W-1:0];
      if (ctl.latchFb)  fbR     <= quot[FB_W-1:0];
      if (ctl.nextPre)  preR    <= preR + 1'b1;
      if (ctl.evalFreq && (delta < minDelta)) begin
        minDelta   <= delta;
        found      <= 1'b1;
        bestPre    <= preR;
        bestFb     <= fbR;
        achievedHz <= freqQ;
      end
      if (ctl.finish) valid <= found;
    end
  end

  // R2: the working rate never exceeds the ceiling
  assert_rate_clamped_R2: assert property (@(posedge clk) disable iff (!rstN)
    foutR <= FREQ_W'(CLAMP_HZ));

  // R3: a kept pre-divider keeps the compare frequency inside the band
  assert_pre_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    found |-> ((64'(bestPre) * 64'(CMP_MIN_HZ) <= 64'(frefR)) &&
               (64'(bestPre) * 64'(CMP_MAX_HZ) >= 64'(frefR))));

  // R4: a kept feedback value is always a legal one
  assert_fb_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    found |-> ((bestFb >= FB_W'(FB_MIN)) && (32'(bestFb) <= FB_MAX)
               && (bestFb != FB_W'(FB_SKIP))));

  // R5: the best error never grows within one search
  assert_error_shrinks_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.init |=> (minDelta <= $past(minDelta)));

  // R7: defaults stay in place while nothing is accepted
  assert_defaults_R7: assert property (@(posedge clk) disable iff (!rstN)
    !found |-> ((achievedHz == '0) && (bestPre == PRE_W'(1)) && (bestFb == FB_W'(1))));

  // R8: completion lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: captured inputs only change on an accepted start
  assert_inputs_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.init |=> ($stable(frefR) && $stable(foutR)));

endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtl_t  ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_MINGO, S_MIN, S_MAXGO, S_MAX, S_CHK,
    S_FB, S_FREQGO, S_FREQ, S_FIN
  } state_e;

  state_e state, nextState;

  always_comb begin
    ctl       = '0;
    ctl.op    = OP_MIN;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.init  = 1'b1;
        nextState = S_MINGO;
      end
      S_MINGO: begin
        ctl.divGo = 1'b1;
        ctl.op    = OP_MIN;
        nextState = S_MIN;
      end
      S_MIN: if (stat.divDone) begin
        ctl.latchMin = 1'b1;
        nextState    = S_MAXGO;
      end
      S_MAXGO: begin
        ctl.divGo = 1'b1;
        ctl.op    = OP_MAX;
        nextState = S_MAX;
      end
      S_MAX: if (stat.divDone) begin
        ctl.latchMax = 1'b1;
        nextState    = S_CHK;
      end
      S_CHK: begin
        if (stat.preOver) nextState = S_FIN;
        else begin
          ctl.divGo = 1'b1;
          ctl.op    = OP_FB;
          nextState = S_FB;
        end
      end
      S_FB: begin
        ctl.op = OP_FB;
        if (stat.divDone) begin
          if (stat.fbOk) begin
            ctl.latchFb = 1'b1;
            nextState   = S_FREQGO;
          end else begin
            ctl.nextPre = 1'b1;
            nextState   = S_CHK;
          end
        end
      end
      S_FREQGO: begin
        ctl.divGo = 1'b1;
        ctl.op    = OP_FREQ;
        nextState = S_FREQ;
      end
      S_FREQ: begin
        ctl.op = OP_FREQ;
        if (stat.divDone) begin
          ctl.evalFreq = 1'b1;
          if (stat.exact) nextState = S_FIN;
          else begin
            ctl.nextPre = 1'b1;
            nextState   = S_CHK;
          end
        end
      end
      default: begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int          FREQ_W     = 32,
  parameter int unsigned CLAMP_HZ   = 1000000000,
  parameter int unsigned CMP_MIN_HZ = 5000000,
  parameter int unsigned CMP_MAX_HZ = 40000000,
  parameter int unsigned FB_MIN     = 12,
  parameter int unsigned FB_MAX     = 511,
  parameter int unsigned FB_SKIP    = 15,
  localparam int PRE_W = $clog2(((64'd1 << (FREQ_W - 1)) / CMP_MIN_HZ) + 64'd2),
  localparam int FB_W  = $clog2(FB_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] refHz,
  input  logic [FREQ_W-1:0] rateHz,
  output logic              done,
  output logic              valid,
  output logic [PRE_W-1:0]  bestPre,
  output logic [FB_W-1:0]   bestFb,
  output logic [FREQ_W-1:0] achievedHz
);
  dpCtl_t  ctl;
  dpStat_t stat;

  pll_search_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctl   (ctl)
  );

  pll_search_dp #(
    .FREQ_W     (FREQ_W),
    .PRE_W      (PRE_W),
    .FB_W       (FB_W),
    .CLAMP_HZ   (CLAMP_HZ),
    .CMP_MIN_HZ (CMP_MIN_HZ),
    .CMP_MAX_HZ (CMP_MAX_HZ),
    .FB_MIN     (FB_MIN),
    .FB_MAX     (FB_MAX),
    .FB_SKIP    (FB_SKIP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .refHz      (refHz),
    .rateHz     (rateHz),
    .stat       (stat),
    .done       (done),
    .valid      (valid),
    .bestPre    (bestPre),
    .bestFb     (bestFb),
    .achievedHz (achievedHz)
  );

endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] refHz = '0;
  logic [31:0] rateHz = '0;
  logic        done, valid;
  logic [8:0]  bestPre, bestFb;
  logic [31:0] achievedHz;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rstN(rstN), .start(start), .refHz(refHz), .rateHz(rateHz),
    .done(done), .valid(valid), .bestPre(bestPre), .bestFb(bestFb),
    .achievedHz(achievedHz)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // model built from the requirements
  task automatic model(input longint r, input longint t, output longint p,
                       output longint f, output longint hz, output bit ok);
    longint fref, fout, minP, maxP, best, fb, fr, d;
    fref = r / 2;
    fout = (t > 1000000000) ? 1000000000 : t;
    minP = (fref + 39999999) / 40000000;
    maxP = fref / 5000000;
    p = 1; f = 1; hz = 0; ok = 0; best = 64'hffffffff;
    for (longint pre = minP; pre <= maxP; pre++) begin
      if (pre == 0) continue;
      fb = fout * pre / fref;
      if (fb < 12 || fb > 511 || fb == 15) continue;
      fr = fb * fref / pre;
      d  = (fout >= fr) ? fout - fr : fr - fout;
      if (d == 0) begin
        p = pre; f = fb; hz = fr; ok = 1;
        break;
      end else if (d < best) begin
        p = pre; f = fb; hz = fr; ok = 1; best = d;
      end
    end
  endtask

  task automatic runSearch(input longint r, input longint t, output int lat);
    int n;
    @(negedge clk);
    refHz = 32'(r); rateHz = 32'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > WAIT_LIMIT) begin
        chk(0, "WDOG", "search timeout cycles", n, WAIT_LIMIT);
        finishRun();
      end
    end
    lat = n;
  endtask

  task automatic expectResult(input string req, input longint r, input longint t);
    longint p, f, hz;
    bit ok;
    model(r, t, p, f, hz, ok);
    chk(bestPre == 9'(p), req, "bestPre", bestPre, p);
    chk(bestFb == 9'(f), req, "bestFb", bestFb, f);
    chk(achievedHz == 32'(hz), req, "achievedHz", achievedHz, hz);
    chk(valid == ok, req, "valid", valid, ok);
  endtask

  task automatic testReset();
    chk(done == 0, "R10", "done", done, 0);
    chk(valid == 0, "R10", "valid", valid, 0);
    chk(bestPre == 1, "R10", "bestPre", bestPre, 1);
    chk(bestFb == 1, "R10", "bestFb", bestFb, 1);
    chk(achievedHz == 0, "R10", "achievedHz", achievedHz, 0);
  endtask

  task automatic testNearest();  // R5: 12 MHz ref, pre 2 fb 83 gives 498 MHz
    int lat;
    runSearch(24000000, 500000000, lat);
    chk(bestPre == 2, "R5", "bestPre", bestPre, 2);
    chk(bestFb == 83, "R5", "bestFb", bestFb, 83);
    chk(achievedHz == 498000000, "R5", "achievedHz", achievedHz, 498000000);
    chk(valid == 1, "R7", "valid after accept", valid, 1);
  endtask

  task automatic testClampTie();  // R2 with an R5 tie: pre 1 kept
    int lat;
    runSearch(24000000, 64'd3000000000, lat);
    chk(achievedHz == 996000000, "R2", "achievedHz", achievedHz, 996000000);
    chk(bestPre == 1, "R5", "tie keeps first pre", bestPre, 1);
    expectResult("R2", 24000000, 64'd3000000000);
  endtask

  task automatic testSkipFb();  // R4: fb 15 rejected, fb below 12 rejected
    int lat;
    runSearch(24000000, 180000000, lat);
    chk(bestPre == 2, "R4", "skip 15 bestPre", bestPre, 2);
    chk(bestFb == 30, "R4", "skip 15 bestFb", bestFb, 30);
    runSearch(24000000, 100000000, lat);
    chk(bestFb == 16, "R4", "below 12 bestFb", bestFb, 16);
    chk(achievedHz == 96000000, "R4", "below 12 achievedHz", achievedHz, 96000000);
  endtask

  task automatic testNoCandidate();  // R7
    int lat;
    runSearch(8000000, 400000000, lat);
    chk(valid == 0, "R7", "empty window valid", valid, 0);
    chk(achievedHz == 0, "R7", "empty window hz", achievedHz, 0);
    chk(bestPre == 1 && bestFb == 1, "R7", "empty window pre", bestPre, 1);
    runSearch(24000000, 50000000, lat);
    chk(valid == 0, "R7", "all fb low valid", valid, 0);
    chk(achievedHz == 0, "R7", "all fb low hz", achievedHz, 0);
  endtask

  task automatic testOddRef();  // R1
    int lat;
    runSearch(24000001, 480000000, lat);
    chk(achievedHz == 480000000, "R1", "halved ref hz", achievedHz, 480000000);
    chk(bestFb == 40, "R1", "halved ref fb", bestFb, 40);
  endtask

  task automatic testEarlyExit();  // R6
    int latExact, latFull;
    runSearch(24000000, 480000000, latExact);
    chk(bestPre == 1 && achievedHz == 480000000, "R6", "exact pre", bestPre, 1);
    runSearch(24000000, 479000000, latFull);
    chk(latExact < latFull, "R6", "exact search shorter", latExact, latFull);
  endtask

  task automatic testWide();  // R3
    int lat;
    runSearch(400000000, 1234567891, lat);
    expectResult("R3", 400000000, 1234567891);
    runSearch(200000000, 333333333, lat);
    expectResult("R3", 200000000, 333333333);
  endtask

  task automatic testBusyStart();  // R9
    int n;
    @(negedge clk);
    refHz = 24000000; rateHz = 500000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rateHz = 480000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1, "R9", "done seen", done, 1);
    chk(achievedHz == 498000000, "R9", "first request kept", achievedHz, 498000000);
    // R8: single-cycle done, outputs held
    @(negedge clk);
    chk(done == 0, "R8", "done one cycle", done, 0);
    refHz = 400000000; rateHz = 100000000;
    repeat (20) @(negedge clk);
    chk(done == 0, "R8", "no spurious done", done, 0);
    chk(achievedHz == 498000000 && bestPre == 2, "R8", "outputs held",
        achievedHz, 498000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNearest();
    testClampTie();
    testSkipFb();
    testNoCandidate();
    testOddRef();
    testEarlyExit();
    testWide();
    testBusyStart();
    finishRun();
  end

endmodule